// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block sits between a 32-bit register bus and the channels of a multi-channel event timer. It owns the free-running 64-bit main counter, a fixed capability word, a small global configuration register and the interrupt status view. It also decodes the per-channel address window and steers those accesses to the channel blocks, which hold the comparators and the interrupt logic.

The counter advances by one on every `tick_en` pulse while the global enable bit is set. When the bit is cleared, the count freezes and keeps its value until counting resumes or software overwrites it. Software reaches every 64-bit quantity as two 32-bit words, the low word at offset +0 and the high word at offset +4. Counting is not atomic across the halves, so a consistent 64-bit read takes three reads: high, then low, then high again.

When the enable bit is set, the block gives the channels a one-cycle arm pulse. When the bit is cleared, it gives them a one-cycle disarm pulse.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the counter and the global configuration are 0, `rd_data` and `rd_valid` are 0, and no arm, disarm or forwarding strobe is active.
- R2: A read at 0x000 returns 0x8086A001 with NUM_CH-1 placed in bits 12:8. A read at 0x004 returns PERIOD_FS, the tick period in femtoseconds. Writes to either address change nothing.
- R3: The configuration word is at 0x010. Bit 0 is the enable and bit 1 routes legacy interrupts; the bit-1 value appears on `cfg_legacy`. A write changes only these two bits, and every other bit reads as 0. The upper word at 0x014 always reads 0 and ignores writes.
- R4: While enabled, the counter rises by exactly 1 on each cycle with `tick_en` high. While halted, the counter holds its value regardless of `tick_en`.
- R5: The counter low word is at 0x0F0 and the high word is at 0x0F4. Either word can be written whether the counter is enabled or halted. A write to a word wins over a tick in the same cycle. Reads return the live count when enabled and the frozen count when halted.
- R6: When a write moves the enable bit from 0 to 1, `ch_arm` pulses for one cycle with bit n set for each channel whose `ch_cmp_max[n]` is low at the write. When a write moves the enable bit from 1 to 0, `ch_disarm` pulses all ones for one cycle. A write that leaves the enable bit unchanged gives no pulse.
- R7: Channel n occupies 0x100+0x20·n. An aligned write there to offset 0x00–0x14 raises bit n of `ch_wr_en` in that same cycle, with `ch_reg_off` set to the offset and `ch_wdata` set to the data. An aligned read there returns word n of `ch_rdata`.
- R8: The following accesses read as 0 and forward nothing:
  - a channel index at or above NUM_CH;
  - a channel offset of 0x18 or 0x1C;
  - an unassigned global address;
  - any address with bits 1:0 not zero.
- R9: A read at 0x020 returns `ch_irq_lvl` zero-extended. A write there drives `ch_isr_clr` = wdata & `ch_irq_lvl` for that cycle.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick strobe |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cfg_legacy | output | 1 | Legacy routing bit |
| ch_wr_en | output | NUM_CH | One-hot channel write strobe |
| ch_reg_off | output | 5 | Offset within the channel window |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32·NUM_CH | Channel read words, channel n at bits 32n+31:32n |
| ch_cmp_max | input | NUM_CH | Channel comparator is all ones |
| ch_irq_lvl | input | NUM_CH | Channel interrupt status |
| ch_isr_clr | output | NUM_CH | Status clear strobe |
| ch_arm | output | NUM_CH | Arm pulse on enable rise |
| ch_disarm | output | NUM_CH | Disarm pulse on enable fall |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- the single step of the counter while enabled, and its stillness while halted;
- the one-cycle width of the arm and disarm pulses;
- the one-hot channel write strobe;
- the silence of the channel strobes on misaligned addresses;
- the one-cycle read latency.

Only the bench scenarios can show that each address returns the right value:
- the capability encoding;
- the masked configuration bits;
- the 32-bit carry into the high counter word;
- the rule that a write wins over a same-cycle tick;
- the zero reads of unimplemented channels and offsets.

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int NUM_CH    = 3,
  parameter int PERIOD_FS = 10_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [9:0]            req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  cfg_legacy,
  output logic [NUM_CH-1:0]     ch_wr_en,
  output logic [4:0]            ch_reg_off,
  output logic [31:0]           ch_wdata,
  input  logic [32*NUM_CH-1:0]  ch_rdata,
  input  logic [NUM_CH-1:0]     ch_cmp_max,
  input  logic [NUM_CH-1:0]     ch_irq_lvl,
  output logic [NUM_CH-1:0]     ch_isr_clr,
  output logic [NUM_CH-1:0]     ch_arm,
  output logic [NUM_CH-1:0]     ch_disarm
);
  localparam logic [31:0] CAP_LO = 32'h8086A001 | (32'(NUM_CH - 1) << 8);
  localparam logic [31:0] CAP_HI = 32'(PERIOD_FS);
  localparam logic [4:0]  LAST_OFF = 5'h14;

  logic        en_q;
  logic [63:0] cnt_q;

  wire acc = req_valid && (req_addr[1:0] == 2'b00);
  wire wr  = acc && req_write;

  wire sel_cap_lo = req_addr == 10'h000;
  wire sel_cap_hi = req_addr == 10'h004;
  wire sel_cfg    = req_addr == 10'h010;
  wire sel_sts    = req_addr == 10'h020;
  wire sel_cnt_lo = req_addr == 10'h0F0;
  wire sel_cnt_hi = req_addr == 10'h0F4;

  wire [4:0] ch_idx = req_addr[9:5] - 5'd8;
  wire       in_win = req_addr[9:8] != 2'b00;
  wire       ch_ok  = in_win && (32'(ch_idx) < NUM_CH) && (req_addr[4:0] <= LAST_OFF);

  wire wr_cfg    = wr && sel_cfg;
  wire wr_cnt_lo = wr && sel_cnt_lo;
  wire wr_cnt_hi = wr && sel_cnt_hi;
  wire cnt_wr    = wr_cnt_lo || wr_cnt_hi;
  wire en_rise   = wr_cfg && !en_q && req_wdata[0];
  wire en_fall   = wr_cfg && en_q && !req_wdata[0];

  assign ch_wr_en   = (wr && ch_ok) ? (NUM_CH'(1) << ch_idx) : '0;
  assign ch_reg_off = req_addr[4:0];
  assign ch_wdata   = req_wdata;
  assign ch_isr_clr = (wr && sel_sts) ? (req_wdata[NUM_CH-1:0] & ch_irq_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      cfg_legacy <= 1'b0;
      ch_arm     <= '0;
      ch_disarm  <= '0;
    end else begin
      if (wr_cfg) begin
        en_q       <= req_wdata[0];
        cfg_legacy <= req_wdata[1];
      end
      ch_arm    <= en_rise ? ~ch_cmp_max : '0;
      ch_disarm <= en_fall ? '1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (wr_cnt_lo)
      cnt_q[31:0] <= req_wdata;
    else if (wr_cnt_hi)
      cnt_q[63:32] <= req_wdata;
    else if (en_q && tick_en)
      cnt_q <= cnt_q + 64'd1;
  end

  logic [31:0] ch_word;
  always_comb begin
    ch_word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_idx == 5'(i)) ch_word = ch_rdata[i*32 +: 32];
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (acc) begin
      if (in_win)          rd_next = ch_ok ? ch_word : '0;
      else if (sel_cap_lo) rd_next = CAP_LO;
      else if (sel_cap_hi) rd_next = CAP_HI;
      else if (sel_cfg)    rd_next = {30'd0, cfg_legacy, en_q};
      else if (sel_sts)    rd_next = 32'(ch_irq_lvl);
      else if (sel_cnt_lo) rd_next = cnt_q[31:0];
      else if (sel_cnt_hi) rd_next = cnt_q[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1)); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q)); // R4
  AST_ARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm != '0) |=> (ch_arm == '0)); // R6
  AST_DISARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_disarm != '0) |=> (ch_disarm == '0)); // R6
  AST_CH_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_en)); // R7
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |-> (ch_wr_en == '0 && ch_isr_clr == '0)); // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid); // R10
endmodule

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
  localparam int NCH = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, cfg_legacy;
  logic [31:0] rd_data, ch_wdata;
  logic [NCH-1:0] ch_wr_en, ch_isr_clr, ch_arm, ch_disarm;
  logic [4:0] ch_reg_off;
  logic [32*NCH-1:0] ch_rdata = {32'hCC00_0002, 32'hCC00_0001, 32'hCC00_0000};
  logic [NCH-1:0] ch_cmp_max = 3'b000;
  logic [NCH-1:0] ch_irq_lvl = 3'b101;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  evt_timer_regs #(.NUM_CH(NCH), .PERIOD_FS(10_000_000)) u_evt_timer_regs (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_legacy(cfg_legacy),
    .ch_wr_en(ch_wr_en), .ch_reg_off(ch_reg_off), .ch_wdata(ch_wdata),
    .ch_rdata(ch_rdata), .ch_cmp_max(ch_cmp_max), .ch_irq_lvl(ch_irq_lvl),
    .ch_isr_clr(ch_isr_clr), .ch_arm(ch_arm), .ch_disarm(ch_disarm));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // {req[78:75], write[74], addr[73:64], wdata[63:32], expected[31:0]}
  localparam logic [78:0] VEC [0:18] = '{
    {4'd2,  1'b0, 10'h000, 32'h0,        32'h8086A201}, // R2
    {4'd2,  1'b1, 10'h000, 32'hFFFFFFFF, 32'h0},
    {4'd2,  1'b0, 10'h000, 32'h0,        32'h8086A201}, // R2
    {4'd2,  1'b0, 10'h004, 32'h0,        32'h00989680}, // R2
    {4'd3,  1'b1, 10'h010, 32'hFFFFFFFC, 32'h0},
    {4'd3,  1'b0, 10'h010, 32'h0,        32'h0},        // R3
    {4'd3,  1'b1, 10'h014, 32'hFFFFFFFF, 32'h0},
    {4'd3,  1'b0, 10'h014, 32'h0,        32'h0},        // R3
    {4'd5,  1'b1, 10'h0F0, 32'h12345678, 32'h0},
    {4'd5,  1'b1, 10'h0F4, 32'h0000ABCD, 32'h0},
    {4'd5,  1'b0, 10'h0F0, 32'h0,        32'h12345678}, // R5
    {4'd5,  1'b0, 10'h0F4, 32'h0,        32'h0000ABCD}, // R5
    {4'd7,  1'b0, 10'h100, 32'h0,        32'hCC000000}, // R7
    {4'd7,  1'b0, 10'h148, 32'h0,        32'hCC000002}, // R7
    {4'd8,  1'b0, 10'h160, 32'h0,        32'h0},        // R8
    {4'd8,  1'b0, 10'h118, 32'h0,        32'h0},        // R8
    {4'd8,  1'b0, 10'h0F1, 32'h0,        32'h0},        // R8
    {4'd8,  1'b0, 10'h030, 32'h0,        32'h0},        // R8
    {4'd9,  1'b0, 10'h020, 32'h0,        32'h00000005}  // R9
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 legacy", cfg_legacy, 0);
    check("R1 arm", ch_arm, 0);
    access(0, 10'h0F0, 0);
    check("R1 counter", rd_data, 0);

    for (int i = 0; i < 19; i++) begin
      access(VEC[i][74], VEC[i][73:64], VEC[i][63:32]);
      if (!VEC[i][74]) begin
        check($sformatf("R%0d vec%0d", VEC[i][78:75], i), rd_data, VEC[i][31:0]);
        check("R10 rd_valid", rd_valid, 1);
      end
    end

    access(1, 10'h010, 32'h2);
    access(0, 10'h010, 0);
    check("R3 legacy read", rd_data, 2);
    check("R3 legacy pin", cfg_legacy, 1);

    access(1, 10'h0F0, 32'hFFFFFFFE);
    access(1, 10'h0F4, 32'h0);
    ch_cmp_max = 3'b010;
    access(1, 10'h010, 32'h3);
    check("R6 arm mask", ch_arm, 3'b101);
    @(negedge clk);
    check("R6 arm one cycle", ch_arm, 0);
    ticks(3);
    access(1, 10'h010, 32'h2);
    check("R6 disarm", ch_disarm, 3'b111);
    ticks(5);
    access(0, 10'h0F0, 0);
    check("R4 carry low", rd_data, 1);
    access(0, 10'h0F4, 0);
    check("R4 carry high", rd_data, 1);
    access(1, 10'h010, 32'h2);
    check("R6 no pulse on same", {ch_arm, ch_disarm}, 0);

    access(1, 10'h010, 32'h3);
    @(negedge clk);
    tick_en = 1'b1; req_valid = 1'b1; req_write = 1'b1;
    req_addr = 10'h0F0; req_wdata = 32'h10;
    @(negedge clk);
    tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    access(1, 10'h010, 32'h0);
    access(0, 10'h0F0, 0);
    check("R5 write beats tick", rd_data, 32'h10);

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h14C; req_wdata = 32'hDEAD0001;
    #1;
    check("R7 wr_en", ch_wr_en, 3'b100);
    check("R7 offset", ch_reg_off, 5'h0C);
    check("R7 wdata", ch_wdata, 32'hDEAD0001);
    req_addr = 10'h170;
    #1 check("R8 bad channel", ch_wr_en, 0);
    req_addr = 10'h11C;
    #1 check("R8 bad offset", ch_wr_en, 0);
    req_addr = 10'h020; req_wdata = 32'hFFFFFFFF;
    #1 check("R9 isr clear", ch_isr_clr, 3'b101);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(0, 10'h010, 0);
    check("R1 cfg after reset", rd_data, 0);
    access(0, 10'h0F0, 0);
    check("R1 counter after reset", rd_data, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule